// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Status Flags

This block buffers 18-bit words between a producer and a consumer. Each side has its own clock. The two clocks may be one net or fully unrelated. The producer stores a word on every write-clock edge where its write enable is high. The consumer takes a word on every read-clock edge where its read enable is high. The write and read pointers cross between the domains as Gray code. The synchronizer on each crossing is either two or three flops deep, set by a static input.

A static mode input picks how the read side behaves:

- **Standard timing:** a request returns the word one read-clock edge later.
- **Fall-through timing:** an internal output register is refilled from the memory by itself, so the oldest word is always presented at the output. A request only acknowledges that word.

The mode also sets the meaning of the two fixed flag pins:

- In standard timing they report empty and full.
- In fall-through timing they report output-ready and input-ready.

Three level flags are also driven: half-full, almost-empty and almost-full. The two almost thresholds live in loadable offset registers. Each returns to seven words after reset. A parameter decides whether the almost flags come straight from the pointer difference or pass through a register in their own clock domain.

Top module: `dual_clk_fifo`

## Requirements
- R1: In standard mode, words leave in the order they were written. A read accepted at a read-clock edge places the word on `rd_data` with `rd_valid` high during the following cycle.
- R2: In standard mode, `rd_flag` is high while no word is stored. With `dbl_sync` low, it falls at the second read-clock edge after the edge that stored the first word.
- R3: In standard mode, `wr_flag` is high once DEPTH words are stored. A write while it is high is ignored and does not disturb the stored words.
- R4: A read request while the memory is empty produces no `rd_valid`, and the next word written is still read out correctly.
- R5: In fall-through mode, the first word written appears on `rd_data` with no read request, and `rd_flag` (output-ready) goes high. `rd_flag` stays high until the word is taken with `rd_en`.
- R6: In fall-through mode, `wr_flag` (input-ready) is high after reset. It stays high while the memory holds fewer than DEPTH words, so total capacity is DEPTH+1 including the output register. It is low when the memory is full.
- R7: `half_full` is high exactly when the write-side count exceeds DEPTH/2.
- R8: `almost_empty` is high when the read-side count is at most the empty offset. The empty offset defaults to 7.
- R9: `almost_full` is high when the write-side count is at least DEPTH minus the full offset. The full offset defaults to 7.
- R10: When `ld_en` and `wr_en` are both high at a write-clock edge, the low bits of `wr_data` are loaded into an offset register and nothing is stored in memory. The first such edge loads the empty offset, the second loads the full offset, and the third wraps back to the empty offset.
- R11: Reset (`rst_n` low) empties the FIFO, lowers full/half-full/almost-full, raises almost-empty and restores both offsets to 7.
- R12: `out_en` low forces `rd_valid` low without changing the stored data.
- R13: With `dbl_sync` high, the fall of the standard-mode empty flag after a write takes one read-clock edge longer than with it low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| fwft_mode | input | 1 | 0 = standard timing, 1 = fall-through timing (change only in reset) |
| dbl_sync | input | 1 | 0 = two-flop pointer synchronizers, 1 = three-flop (static) |
| wr_en | input | 1 | Write or offset-load request |
| ld_en | input | 1 | Steers enabled writes into the offset registers |
| wr_data | input | 18 | Write data; low bits carry offset values during loads |
| rd_en | input | 1 | Read request (standard) or acknowledge (fall-through) |
| out_en | input | 1 | Gates `rd_valid` |
| rd_data | output | 18 | Read data |
| rd_valid | output | 1 | `rd_data` holds a valid word |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| half_full | output | 1 | Count above half of DEPTH |
| almost_empty | output | 1 | Read-side count at or below the empty offset |
| almost_full | output | 1 | Write-side count at or above DEPTH minus the full offset |

## Verification
The bench fills the memory to the last slot and writes once more. A design that let that write through would overwrite the oldest word, and the scoreboard would see a wrong or missing word on the drain. It issues reads against an empty memory. A design that advanced its read pointer there would then return a stale word instead of the next one written. It checks the level flags one word on either side of each threshold, both with the default offsets and after a wrapping three-value load, so an off-by-one compare or a swapped load order shows as a flag at the wrong count. In fall-through mode it checks that the first word shows up unrequested and that capacity grows by one. It also times the empty-flag release for both synchronizer depths.

// File: rtl/fifo_pkg.sv
package fifo_pkg;

    // Word width of the data path.
    localparam int unsigned WORD_W = 18;

    // Offset value restored into both threshold registers at reset.
    localparam int unsigned DEF_OFFSET = 7;

    // Read-port timing variant.
    typedef enum logic {
        RD_STD  = 1'b0,
        RD_FWFT = 1'b1
    } rd_mode_e;

endpackage

// File: rtl/fifo_mem.sv
module fifo_mem #(
    parameter int unsigned DW = 18,
    parameter int unsigned AW = 8
) (
    input  logic          wr_clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int unsigned WORDS = 1 << AW;

    logic [DW-1:0] store [WORDS];

    // Write port belongs to the write clock domain.
    always_ff @(posedge wr_clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Read port is combinational; the read controller registers the result.
    assign rdata = store[raddr];

endmodule

// File: rtl/fifo_ptr_sync.sv
module fifo_ptr_sync #(
    parameter int unsigned PW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dbl,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] bin_out
);

    typedef struct packed {
        logic [PW-1:0] s0;
        logic [PW-1:0] s1;
        logic [PW-1:0] s2;
    } sync_t;

    sync_t         st_d;
    sync_t         st_q;
    logic [PW-1:0] gray_sel;

    always_comb begin
        st_d.s0 = gray_in;
        st_d.s1 = st_q.s0;
        st_d.s2 = st_q.s1;

        // Two or three flops, chosen by the static depth select.
        gray_sel = dbl ? st_q.s2 : st_q.s1;

        // Gray to binary: each bit is the parity of itself and all higher bits.
        for (int i = 0; i < int'(PW); i++) begin
            bin_out[i] = ^(gray_sel >> i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
    import fifo_pkg::*;
#(
    parameter int unsigned DEPTH      = 256,
    parameter int unsigned AW         = 8,
    parameter bit          ALMOST_REG = 1'b0
) (
    input  logic          wr_clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_val,
    input  logic [AW:0]   rptr_sync,
    output logic          mem_we,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wptr,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          half_full,
    output logic          almost_full,
    output logic [AW-1:0] ae_off
);

    localparam int unsigned   PW      = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);
    localparam logic [AW-1:0] DEF_OFF = AW'(DEF_OFFSET);

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic [AW-1:0] ae;
        logic [AW-1:0] af;
        logic          sel;
        logic          af_flag;
    } wst_t;

    localparam wst_t RST_ST = '{
        ptr:     '0,
        gray:    '0,
        ae:      DEF_OFF,
        af:      DEF_OFF,
        sel:     1'b0,
        af_flag: 1'b0
    };

    wst_t          st_d;
    wst_t          st_q;
    logic [PW-1:0] fill_now;
    logic [PW-1:0] fill_next;
    logic          is_full;
    logic          push;
    logic          load;
    logic          af_comb;

    always_comb begin
        st_d = st_q;

        fill_now = st_q.ptr - rptr_sync;
        is_full  = (fill_now == DEPTH_P);

        // Load cycles never touch the memory.
        load = wr_en && ld_en;
        push = wr_en && !ld_en && !is_full;

        if (push) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
        st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);

        // Offset load alternates: empty offset first, then full offset.
        if (load) begin
            if (!st_q.sel) begin
                st_d.ae = ld_val;
            end else begin
                st_d.af = ld_val;
            end
            st_d.sel = !st_q.sel;
        end

        // Registered variant sees the count after this edge's write.
        fill_next    = st_d.ptr - rptr_sync;
        st_d.af_flag = (fill_next >= (DEPTH_P - {1'b0, st_d.af}));

        af_comb = (fill_now >= (DEPTH_P - {1'b0, st_q.af}));
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_we      = push;
    assign waddr       = st_q.ptr[AW-1:0];
    assign wptr        = st_q.ptr;
    assign wgray       = st_q.gray;
    assign full        = is_full;
    assign half_full   = (fill_now > HALF_P);
    assign almost_full = ALMOST_REG ? st_q.af_flag : af_comb;
    assign ae_off      = st_q.ae;

endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
    import fifo_pkg::*;
#(
    parameter int unsigned DEPTH      = 256,
    parameter int unsigned AW         = 8,
    parameter int unsigned DW         = 18,
    parameter bit          ALMOST_REG = 1'b0
) (
    input  logic          rd_clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          out_en,
    input  logic          fwft,
    input  logic [AW:0]   wptr_sync,
    input  logic [AW-1:0] ae_off,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rptr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid,
    output logic          rd_flag,
    output logic          almost_empty
);

    localparam int unsigned PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic [PW-1:0] gray;
        logic [DW-1:0] dout;
        logic          rdy;
        logic          vld;
        logic          ae_flag;
    } rst_t;

    localparam rst_t RST_ST = '{
        ptr:     '0,
        gray:    '0,
        dout:    '0,
        rdy:     1'b0,
        vld:     1'b0,
        ae_flag: 1'b1
    };

    rst_t          st_d;
    rst_t          st_q;
    rd_mode_e      mode;
    logic          mem_empty;
    logic          take;
    logic          consume;
    logic [PW-1:0] level_now;
    logic [PW-1:0] level_next;
    logic          ae_comb;

    assign mode = rd_mode_e'(fwft);

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        mem_empty = (wptr_sync == st_q.ptr);

        if (mode == RD_FWFT) begin
            // Output register refills itself whenever it is free or being taken.
            consume = rd_en && st_q.rdy;
            take    = !mem_empty && (!st_q.rdy || consume);
            if (take) begin
                st_d.rdy = 1'b1;
            end else if (consume) begin
                st_d.rdy = 1'b0;
            end
        end else begin
            consume  = 1'b0;
            take     = rd_en && !mem_empty;
            st_d.vld = take;
            st_d.rdy = 1'b0;
        end

        if (take) begin
            st_d.dout = mem_rdata;
            st_d.ptr  = st_q.ptr + 1'b1;
        end
        st_d.gray = st_d.ptr ^ (st_d.ptr >> 1);

        // Read-side level counts the held output word in fall-through mode.
        level_now  = wptr_sync - st_q.ptr
                   + {{(PW-1){1'b0}}, (st_q.rdy && (mode == RD_FWFT))};
        level_next = wptr_sync - st_d.ptr
                   + {{(PW-1){1'b0}}, (st_d.rdy && (mode == RD_FWFT))};

        st_d.ae_flag = (level_next <= {1'b0, ae_off});
        ae_comb      = (level_now  <= {1'b0, ae_off});
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign raddr        = st_q.ptr[AW-1:0];
    assign rptr         = st_q.ptr;
    assign rgray        = st_q.gray;
    assign rd_data      = st_q.dout;
    assign rd_flag      = (mode == RD_FWFT) ? st_q.rdy : mem_empty;
    assign rd_valid     = out_en && ((mode == RD_FWFT) ? st_q.rdy : st_q.vld);
    assign almost_empty = ALMOST_REG ? st_q.ae_flag : ae_comb;

endmodule

// File: rtl/dual_clk_fifo.sv
module dual_clk_fifo
    import fifo_pkg::*;
#(
    parameter int unsigned DEPTH      = 256,
    parameter bit          ALMOST_REG = 1'b0
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              fwft_mode,
    input  logic              dbl_sync,
    input  logic              wr_en,
    input  logic              ld_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              out_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              rd_flag,
    output logic              wr_flag,
    output logic              half_full,
    output logic              almost_empty,
    output logic              almost_full
);

    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned PW = AW + 1;

    logic              mem_we;
    logic [AW-1:0]     waddr;
    logic [AW-1:0]     raddr;
    logic [WORD_W-1:0] mem_rdata;
    logic [PW-1:0]     wptr_bin;
    logic [PW-1:0]     wptr_gray;
    logic [PW-1:0]     rptr_bin;
    logic [PW-1:0]     rptr_gray;
    logic [PW-1:0]     wptr_in_rd;
    logic [PW-1:0]     rptr_in_wr;
    logic [AW-1:0]     ae_off;
    logic              mem_full;

    fifo_mem #(
        .DW (WORD_W),
        .AW (AW)
    ) u_mem (
        .wr_clk (wr_clk),
        .we     (mem_we),
        .waddr  (waddr),
        .wdata  (wr_data),
        .raddr  (raddr),
        .rdata  (mem_rdata)
    );

    fifo_wr_ctl #(
        .DEPTH      (DEPTH),
        .AW         (AW),
        .ALMOST_REG (ALMOST_REG)
    ) u_wr (
        .wr_clk      (wr_clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .ld_en       (ld_en),
        .ld_val      (wr_data[AW-1:0]),
        .rptr_sync   (rptr_in_wr),
        .mem_we      (mem_we),
        .waddr       (waddr),
        .wptr        (wptr_bin),
        .wgray       (wptr_gray),
        .full        (mem_full),
        .half_full   (half_full),
        .almost_full (almost_full),
        .ae_off      (ae_off)
    );

    // Read pointer into the write domain.
    fifo_ptr_sync #(
        .PW (PW)
    ) u_sync_r2w (
        .clk     (wr_clk),
        .rst_n   (rst_n),
        .dbl     (dbl_sync),
        .gray_in (rptr_gray),
        .bin_out (rptr_in_wr)
    );

    // Write pointer into the read domain.
    fifo_ptr_sync #(
        .PW (PW)
    ) u_sync_w2r (
        .clk     (rd_clk),
        .rst_n   (rst_n),
        .dbl     (dbl_sync),
        .gray_in (wptr_gray),
        .bin_out (wptr_in_rd)
    );

    fifo_rd_ctl #(
        .DEPTH      (DEPTH),
        .AW         (AW),
        .DW         (WORD_W),
        .ALMOST_REG (ALMOST_REG)
    ) u_rd (
        .rd_clk       (rd_clk),
        .rst_n        (rst_n),
        .rd_en        (rd_en),
        .out_en       (out_en),
        .fwft         (fwft_mode),
        .wptr_sync    (wptr_in_rd),
        .ae_off       (ae_off),
        .mem_rdata    (mem_rdata),
        .raddr        (raddr),
        .rptr         (rptr_bin),
        .rgray        (rptr_gray),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .rd_flag      (rd_flag),
        .almost_empty (almost_empty)
    );

    // Full in standard timing, input-ready in fall-through timing.
    assign wr_flag = fwft_mode ? !mem_full : mem_full;

endmodule

// File: rtl/fifo_chk.sv
module fifo_chk #(
    parameter int unsigned PW = 9
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          rst_n,
    input logic          fwft_mode,
    input logic          wr_en,
    input logic          ld_en,
    input logic          rd_en,
    input logic          wr_flag,
    input logic          rd_flag,
    input logic          half_full,
    input logic          almost_full,
    input logic          rd_valid,
    input logic [PW-1:0] wptr,
    input logic [PW-1:0] rptr
);

    logic full_s;
    assign full_s = fwft_mode ? !wr_flag : wr_flag;

    // R3: a write against a full memory leaves the write pointer alone
    p_no_overflow_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && !ld_en && full_s) |=> $stable(wptr));

    // R4: a standard read against an empty memory leaves the read pointer alone
    p_no_underflow_r4: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!fwft_mode && rd_en && rd_flag) |=> $stable(rptr));

    // R7: a full memory is always above half
    p_full_hf_r7: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full_s |-> half_full);

    // R9: a full memory is always almost full
    p_full_af_r9: assert property (@(posedge wr_clk) disable iff (!rst_n)
        full_s |-> almost_full);

    // R5: output-ready holds until the word is acknowledged
    p_ready_hold_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (fwft_mode && rd_flag && !rd_en) |=> rd_flag);

    // R10: an offset-load edge stores nothing
    p_load_noptr_r10: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (wr_en && ld_en) |=> $stable(wptr));

    // R1: a standard-mode valid word answers a request on the previous edge
    p_std_valid_r1: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (!fwft_mode && rd_valid) |-> $past(rd_en));

endmodule

bind dual_clk_fifo fifo_chk #(.PW(PW)) u_chk (
    .wr_clk      (wr_clk),
    .rd_clk      (rd_clk),
    .rst_n       (rst_n),
    .fwft_mode   (fwft_mode),
    .wr_en       (wr_en),
    .ld_en       (ld_en),
    .rd_en       (rd_en),
    .wr_flag     (wr_flag),
    .rd_flag     (rd_flag),
    .half_full   (half_full),
    .almost_full (almost_full),
    .rd_valid    (rd_valid),
    .wptr        (wptr_bin),
    .rptr        (rptr_bin)
);

// File: tb/sim_dual_clk_fifo.sv
`timescale 1ns/1ps
module sim_dual_clk_fifo;

    localparam int unsigned DEPTH = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fwft_mode = 1'b0;
    logic        dbl_sync = 1'b0;
    logic        wr_en = 1'b0;
    logic        ld_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        out_en = 1'b1;
    logic [17:0] wr_data = '0;
    logic [17:0] rd_data;
    logic        rd_valid, rd_flag, wr_flag, half_full, almost_empty, almost_full;

    int          n_chk = 0;
    int          n_bad = 0;
    logic [17:0] exp_q[$];
    logic [17:0] exp_w;
    logic [17:0] seq = 18'h00100;

    always #2.5 clk = ~clk;

    dual_clk_fifo #(.DEPTH(DEPTH)) u0 (
        .wr_clk       (clk),
        .rd_clk       (clk),
        .rst_n        (rst_n),
        .fwft_mode    (fwft_mode),
        .dbl_sync     (dbl_sync),
        .wr_en        (wr_en),
        .ld_en        (ld_en),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .out_en       (out_en),
        .rd_data      (rd_data),
        .rd_valid     (rd_valid),
        .rd_flag      (rd_flag),
        .wr_flag      (wr_flag),
        .half_full    (half_full),
        .almost_empty (almost_empty),
        .almost_full  (almost_full)
    );

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard whenever the design hands out a word.
    always @(negedge clk) begin
        if (rst_n && (fwft_mode ? (rd_valid && rd_en) : rd_valid)) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R4 unexpected word: actual %0h expected none", rd_data);
            end else begin
                exp_w = exp_q.pop_front();
                if (rd_data !== exp_w) begin
                    n_bad++;
                    $display("FAIL %s data order: actual %0h expected %0h",
                             fwft_mode ? "R5" : "R1", rd_data, exp_w);
                end
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: back-to-back writes, optionally recorded as expected words.
    task automatic wr_burst(input int n, input bit keep);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            wr_en   = 1'b1;
            wr_data = seq;
            if (keep) exp_q.push_back(seq);
            seq = seq + 18'd1;
        end
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic load_offsets(input logic [17:0] a, input logic [17:0] b, input logic [17:0] c);
        @(posedge clk); #1; ld_en = 1'b1; wr_en = 1'b1; wr_data = a;
        @(posedge clk); #1; wr_data = b;
        @(posedge clk); #1; wr_data = c;
        @(posedge clk); #1; ld_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic drain();
        int guard = 0;
        @(posedge clk); #1;
        rd_en = 1'b1;
        while (exp_q.size() > 0 && guard < 2 * DEPTH + 50) begin
            @(posedge clk); #1;
            guard++;
        end
        rd_en = 1'b0;
        settle(4);
    endtask

    task automatic restart(input bit fw, input bit db);
        @(posedge clk); #1;
        rst_n = 1'b0; fwft_mode = fw; dbl_sync = db;
        wr_en = 1'b0; rd_en = 1'b0; ld_en = 1'b0; out_en = 1'b1;
        exp_q.delete();
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        settle(1);
    endtask

    task automatic release_latency(output int n);
        wr_burst(1, 1'b1);
        n = 0;
        @(negedge clk);
        while (rd_flag && n < 10) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lat;

        // R11: reset state
        restart(1'b0, 1'b0);
        check("R11 empty after reset", rd_flag, 1);
        check("R11 full low after reset", wr_flag, 0);
        check("R11 half_full low", half_full, 0);
        check("R11 almost_empty high", almost_empty, 1);
        check("R11 almost_full low", almost_full, 0);
        check("R11 no valid", rd_valid, 0);

        // R2 / R13: empty release latency for both synchronizer depths
        release_latency(lat);
        check("R2 empty release edges (2-flop)", lat, 2);
        drain();
        restart(1'b0, 1'b1);
        release_latency(lat);
        check("R13 empty release edges (3-flop)", lat, 3);
        drain();

        // R8 R7 R9 R3 with default offsets
        restart(1'b0, 1'b0);
        wr_burst(7, 1'b1);   settle(4);
        check("R8 almost_empty at 7", almost_empty, 1);
        wr_burst(1, 1'b1);   settle(4);
        check("R8 almost_empty at 8", almost_empty, 0);
        wr_burst(120, 1'b1); settle(1);
        check("R7 half_full at 128", half_full, 0);
        wr_burst(1, 1'b1);   settle(1);
        check("R7 half_full at 129", half_full, 1);
        wr_burst(119, 1'b1); settle(1);
        check("R9 almost_full at 248", almost_full, 0);
        wr_burst(1, 1'b1);   settle(1);
        check("R9 almost_full at 249", almost_full, 1);
        wr_burst(6, 1'b1);   settle(1);
        check("R3 full at 255", wr_flag, 0);
        wr_burst(1, 1'b1);   settle(1);
        check("R3 full at 256", wr_flag, 1);
        wr_burst(1, 1'b0);   settle(1);
        check("R3 full after ignored write", wr_flag, 1);
        drain();
        check("R2 empty after drain", rd_flag, 1);
        check("R3 full released after drain", wr_flag, 0);
        check("R7 half_full after drain", half_full, 0);

        // R4: reads against empty memory
        @(posedge clk); #1; rd_en = 1'b1;
        repeat (3) @(posedge clk);
        #1 rd_en = 1'b0;
        settle(2);
        check("R4 no valid on empty read", rd_valid, 0);
        check("R4 still empty", rd_flag, 1);
        wr_burst(1, 1'b1); settle(4);
        drain();

        // R10: wrapping offset load (empty=2, full=20, then empty=4)
        restart(1'b0, 1'b0);
        load_offsets(18'd2, 18'd20, 18'd4);
        settle(4);
        check("R10 load stored nothing", rd_flag, 1);
        wr_burst(4, 1'b1);   settle(4);
        check("R10 almost_empty at 4 (offset 4)", almost_empty, 1);
        wr_burst(1, 1'b1);   settle(4);
        check("R10 almost_empty at 5 (offset 4)", almost_empty, 0);
        wr_burst(230, 1'b1); settle(1);
        check("R10 almost_full at 235 (offset 20)", almost_full, 0);
        wr_burst(1, 1'b1);   settle(1);
        check("R10 almost_full at 236 (offset 20)", almost_full, 1);
        drain();

        // R11: reset mid-stream restores defaults
        wr_burst(10, 1'b0);
        restart(1'b0, 1'b0);
        check("R11 empty after reset with data", rd_flag, 1);
        check("R11 almost_empty after reset", almost_empty, 1);
        wr_burst(7, 1'b1);   settle(4);
        check("R11 default empty offset at 7", almost_empty, 1);
        wr_burst(1, 1'b1);   settle(4);
        check("R11 default empty offset at 8", almost_empty, 0);
        drain();

        // R5 R6 R12: fall-through mode
        restart(1'b1, 1'b0);
        check("R5 not ready after reset", rd_flag, 0);
        check("R6 input ready after reset", wr_flag, 1);
        wr_burst(1, 1'b1);   settle(4);
        check("R5 output ready without request", rd_flag, 1);
        check("R5 first word presented", rd_data, exp_q[0]);
        @(posedge clk); #1; out_en = 1'b0;
        settle(1);
        check("R12 valid gated off", rd_valid, 0);
        check("R12 data kept while gated", rd_data, exp_q[0]);
        @(posedge clk); #1; out_en = 1'b1;
        settle(1);
        check("R12 valid restored", rd_valid, 1);
        drain();
        check("R5 not ready after drain", rd_flag, 0);
        wr_burst(DEPTH, 1'b1); settle(6);
        check("R6 input ready with 256 held", wr_flag, 1);
        wr_burst(1, 1'b1);   settle(1);
        check("R6 input not ready with 257 held", wr_flag, 0);
        wr_burst(1, 1'b0);   settle(1);
        drain();
        check("R6 input ready after drain", wr_flag, 1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule